// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block paces USB frames for a host controller. A 14-bit counter of remaining bit times steps down on each bit-time strobe while the controller is in its operational state. When the counter has reached zero, the next strobe reloads it from a frame interval that software programs. The same reload advances a 16-bit frame number and raises a one-clock start-of-frame pulse.

A new interval written by software does not disturb the frame in progress. It is taken up only at the next reload. Software writes a toggle bit together with the interval, and that bit is copied into a remaining-toggle bit at each reload. Comparing the two toggle bits shows software when a newly written interval has come into force.

On entry to the operational state the counter is loaded from the interval at once. Outside that state the timer is frozen.

Top module: `usb_frame_timer`

## Requirements
- R1: While `op_en_i` is high and was also high in the previous cycle, a `bit_tick_i` strobe decrements a non-zero remaining count by exactly one.
- R2: A strobe that finds the remaining count at zero reloads it with the programmed interval. A frame therefore spans interval+1 strobes.
- R3: At each reload from zero, the remaining-toggle bit takes the value of the interval-toggle bit.
- R4: In the first cycle in which `op_en_i` is high after being low, the remaining count is loaded from the interval. This takes priority over a strobe in the same cycle. No start-of-frame pulse is raised and the frame number does not change.
- R5: The frame number starts at 0 and increases by one at each reload from zero, wrapping from 0xFFFF to 0x0000. Software writes to it are ignored.
- R6: `sof_o` is high for exactly the one clock that follows each reload from zero.
- R7: A write to the interval register leaves the running remaining count undisturbed. The new interval is used at the next reload.
- R8: While `op_en_i` is low, the remaining count, the remaining toggle and the frame number hold their values, and `sof_o` stays low.
- R9: After reset, the interval reads 11999 (0x2EDF), both toggle bits read 0, the remaining count reads 0 and the frame number reads 0.
- R10: The read and write port uses the following fields, and all other bits read 0:
  - Address 0 is the writable interval register, with the interval in bits 13:0 and the interval toggle in bit 31.
  - Address 1 is the remaining register, with the count in bits 13:0 and the remaining toggle in bit 31.
  - Address 2 holds the frame number in bits 15:0.
  - Address 3 reads as 0.
  - Writes to addresses 1, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_en_i | input | 1 | Operational-state enable |
| bit_tick_i | input | 1 | One-clock strobe, once per bit time |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| sof_o | output | 1 | Start-of-frame pulse |

## Verification
The hardest case to reach from the ports is the frame number wrapping from 0xFFFF to 0. At the reset interval this takes 65536 frames of 12000 strobes each. The stimulus programs an interval of 0 and raises a strobe on every clock, which makes each clock a complete frame, and then runs the timer past the wrap point. Two other cases are driven directly. One is entry to the operational state in the same cycle as a strobe. The other is an interval write landing in the middle of a frame, including a write on the same edge as a reload.

// File: rtl/ft_pkg.sv
package ft_pkg;
  typedef enum logic [1:0] {
    ADDR_IVL  = 2'd0,
    ADDR_REM  = 2'd1,
    ADDR_FNUM = 2'd2,
    ADDR_RSVD = 2'd3
  } ft_addr_e;
endpackage

// File: rtl/ft_ivl_reg.sv
module ft_ivl_reg
  import ft_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int IVL_RESET = 11999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  ft_addr_e         addr_i,
  input  logic [CNT_W-1:0] wdata_ivl_i,
  input  logic             wdata_tog_i,
  output logic [CNT_W-1:0] ivl_o,
  output logic             itog_o
);
  localparam logic [CNT_W-1:0] IvlRst = CNT_W'(IVL_RESET);

  logic wr_hit;
  assign wr_hit = wr_i && (addr_i == ADDR_IVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_o  <= IvlRst;
      itog_o <= 1'b0;
    end else if (wr_hit) begin
      ivl_o  <= wdata_ivl_i;
      itog_o <= wdata_tog_i;
    end
  end

  // R10
  ivl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(ivl_o) && $stable(itog_o));
endmodule

// File: rtl/ft_remaining.sv
module ft_remaining #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ivl_i,
  input  logic             itog_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             rtog_o,
  output logic             wrap_o,
  output logic             sof_o
);
  logic op_q;
  logic entry;

  assign entry  = op_i && !op_q;
  // strobe landing on an exhausted count, outside the entry cycle
  assign wrap_o = op_i && op_q && tick_i && (rem_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= 1'b0;
      rem_o  <= '0;
      rtog_o <= 1'b0;
      sof_o  <= 1'b0;
    end else begin
      op_q  <= op_i;
      sof_o <= wrap_o;
      if (entry) begin
        rem_o <= ivl_i;
      end else if (wrap_o) begin
        rem_o  <= ivl_i;
        rtog_o <= itog_i;
      end else if (op_i && tick_i) begin
        rem_o <= rem_o - 1'b1;
      end
    end
  end

  // R1
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && op_q && tick_i && rem_o != '0) |=> rem_o == $past(rem_o) - 1'b1);
  // R2
  reload_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && op_q && tick_i && rem_o == '0) |=> rem_o == $past(ivl_i));
  // R3
  tog_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && op_q && tick_i && rem_o == '0) |=> rtog_o == $past(itog_i));
  // R4
  entry_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && !op_q) |=> rem_o == $past(ivl_i) && !sof_o && $stable(rtog_o));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_i |=> $stable(rem_o) && $stable(rtog_o) && !sof_o);
endmodule

// File: rtl/ft_frame_num.sv
module ft_frame_num #(
  parameter int FN_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [FN_W-1:0] fn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fn_o <= '0;
    else if (adv_i) fn_o <= fn_o + 1'b1;
  end

  // R5
  fn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> fn_o == $past(fn_o) + 1'b1);
  // R5
  fn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(fn_o));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import ft_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int FN_W      = 16,
  parameter int DATA_W    = 32,
  parameter int IVL_RESET = 11999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_en_i,
  input  logic              bit_tick_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sof_o
);
  localparam int TogBit = DATA_W - 1;

  ft_addr_e         addr;
  logic [CNT_W-1:0] ivl, rem;
  logic             itog, rtog, wrap;
  logic [FN_W-1:0]  fn;
  logic             wdata_unused;

  assign addr         = ft_addr_e'(reg_addr_i);
  assign wdata_unused = ^reg_wdata_i[TogBit-1:CNT_W];

  ft_ivl_reg #(.CNT_W(CNT_W), .IVL_RESET(IVL_RESET)) u_ivl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (addr),
    .wdata_ivl_i (reg_wdata_i[CNT_W-1:0]),
    .wdata_tog_i (reg_wdata_i[TogBit]),
    .ivl_o       (ivl),
    .itog_o      (itog)
  );

  ft_remaining #(.CNT_W(CNT_W)) u_rem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_en_i),
    .tick_i (bit_tick_i),
    .ivl_i  (ivl),
    .itog_i (itog),
    .rem_o  (rem),
    .rtog_o (rtog),
    .wrap_o (wrap),
    .sof_o  (sof_o)
  );

  ft_frame_num #(.FN_W(FN_W)) u_fn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (wrap),
    .fn_o   (fn)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      ADDR_IVL: begin
        reg_rdata_o[CNT_W-1:0] = ivl;
        reg_rdata_o[TogBit]    = itog;
      end
      ADDR_REM: begin
        reg_rdata_o[CNT_W-1:0] = rem;
        reg_rdata_o[TogBit]    = rtog;
      end
      ADDR_FNUM: reg_rdata_o[FN_W-1:0] = fn;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R6
  sof_fn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> fn == $past(fn) + 1'b1);
  // R6
  sof_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> sof_o);
endmodule

// File: tb/sim_usb_frame_timer.sv
`timescale 1ns/1ps
module sim_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_en_i = 1'b0, bit_tick_i = 1'b0, reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        sof_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_ivl, m_rem, m_fn;
  bit m_itog, m_rtog, m_sof, m_opp;

  always #2 clk = ~clk;

  usb_frame_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_en_i(op_en_i), .bit_tick_i(bit_tick_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .sof_o(sof_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ivl = 11999; m_itog = 0; m_rem = 0; m_rtog = 0; m_fn = 0; m_sof = 0; m_opp = 0;
    end else begin
      m_sof = 0;
      if (op_en_i && !m_opp) m_rem = m_ivl;
      else if (op_en_i && bit_tick_i) begin
        if (m_rem == 0) begin
          m_rem = m_ivl; m_rtog = m_itog; m_fn = (m_fn + 1) % 65536; m_sof = 1;
        end else m_rem = m_rem - 1;
      end
      if (reg_wr_i && reg_addr_i == 2'd0) begin
        m_ivl = int'(reg_wdata_i[13:0]); m_itog = reg_wdata_i[31];
      end
      m_opp = op_en_i;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: exp_rd = {m_itog, 17'd0, 14'(m_ivl)};
      2'd1: exp_rd = {m_rtog, 17'd0, 14'(m_rem)};
      2'd2: exp_rd = {16'd0, 16'(m_fn)};
      default: exp_rd = '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    string tag;
    case (reg_addr_i)
      2'd0: tag = "R10 interval readback";
      2'd1: tag = "R1 remaining readback";
      2'd2: tag = "R5 frame number readback";
      default: tag = "R10 reserved address";
    endcase
    chk(reg_rdata_o === exp_rd(reg_addr_i), tag, reg_rdata_o, exp_rd(reg_addr_i));
    chk(sof_o === m_sof, "R6 sof pulse", 32'(sof_o), 32'(m_sof));
  endtask

  task automatic cyc(input bit op, input bit tk);
    op_en_i = op; bit_tick_i = tk;
    @(posedge clk); @(negedge clk);
    cmp_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit tk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc(op_en_i, tk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr_i = a; #0.5; v = reg_rdata_o;
  endtask

  initial begin
    logic [31:0] v, prev;
    int gap, last;
    repeat (3) @(negedge clk);
    // R9 reset state
    rd(2'd0, v); chk(v === 32'h0000_2EDF, "R9 reset interval", v, 32'h0000_2EDF);
    rd(2'd1, v); chk(v === 32'h0, "R9 reset remaining", v, 32'h0);
    rd(2'd2, v); chk(v === 32'h0, "R9 reset frame number", v, 32'h0);
    chk(sof_o === 1'b0, "R9 reset sof", 32'(sof_o), 32'h0);
    rst_ni = 1'b1;
    cyc(0, 0);

    // R10 field layout, reserved bits read zero
    wr(2'd0, 32'hFFFF_FFFF, 0);
    rd(2'd0, v); chk(v === 32'h8000_3FFF, "R10 interval fields", v, 32'h8000_3FFF);
    rd(2'd3, v); chk(v === 32'h0, "R10 address 3 reads zero", v, 32'h0);
    wr(2'd0, 32'h8000_0009, 0);

    // R8 idle: strobes change nothing
    for (int i = 0; i < 10; i++) cyc(0, 1);
    rd(2'd1, v); chk(v === 32'h0, "R8 remaining held while idle", v, 32'h0);

    // R4 entry with simultaneous strobe
    cyc(1, 1);
    rd(2'd1, v); chk(v === 32'h0000_0009, "R4 entry loads interval", v, 32'h9);
    chk(sof_o === 1'b0, "R4 no sof at entry", 32'(sof_o), 32'h0);
    rd(2'd2, v); chk(v === 32'h0, "R4 frame number unchanged at entry", v, 32'h0);

    // R2/R6: frame spans interval+1 strobes
    last = -1;
    for (int i = 0; i < 40; i++) begin
      cyc(1, 1);
      if (sof_o) begin
        if (last >= 0) begin
          gap = i - last;
          chk(gap == 10, "R2 frame length", 32'(gap), 32'd10);
        end
        last = i;
      end
    end
    // R3 toggle copied at reload
    rd(2'd1, v); chk(v[31] === 1'b1, "R3 remaining toggle", 32'(v[31]), 32'h1);

    // R7 mid-frame write does not disturb count
    while (m_rem < 3) cyc(1, 1);
    rd(2'd1, prev);
    wr(2'd0, 32'h0000_0004, 1);
    rd(2'd1, v); chk(v[13:0] === prev[13:0] - 14'd1, "R7 count continues after write", 32'(v[13:0]), 32'(prev[13:0] - 14'd1));
    for (int i = 0; i < 30; i++) cyc(1, 1);
    rd(2'd1, v); chk(v[31] === 1'b0, "R3 toggle follows new interval", 32'(v[31]), 32'h0);

    // R5 read-only frame number and remaining
    rd(2'd2, prev);
    wr(2'd2, 32'h0000_1234, 0);
    wr(2'd1, 32'h8000_0777, 0);
    rd(2'd2, v); chk(v === prev, "R5 frame number write ignored", v, prev);
    rd(2'd1, v); chk(v === exp_rd(2'd1), "R10 remaining write ignored", v, exp_rd(2'd1));

    // random strobes, mixed writes, leaving and re-entering
    for (int i = 0; i < 600; i++) begin
      reg_addr_i = 2'($urandom_range(0, 3));
      if (i % 97 == 5) wr(2'd0, {1'($urandom_range(0, 1)), 17'd0, 14'($urandom_range(0, 12))}, 1'($urandom_range(0, 1)));
      else cyc((i % 150) < 120, 1'($urandom_range(0, 1)));
    end

    // R5 wrap: interval 0, strobe every clock
    cyc(0, 0);
    wr(2'd0, 32'h0, 0);
    cyc(1, 0);
    reg_addr_i = 2'd2;
    while (m_fn != 16'hFFFF) cyc(1, 1);
    rd(2'd2, v); chk(v === 32'h0000_FFFF, "R5 frame number at top", v, 32'hFFFF);
    cyc(1, 1);
    rd(2'd2, v); chk(v === 32'h0, "R5 frame number wraps", v, 32'h0);
    chk(sof_o === 1'b1, "R6 sof at wrap", 32'(sof_o), 32'h1);
    for (int i = 0; i < 5; i++) cyc(1, 1);
    cyc(0, 1);
    chk(sof_o === 1'b0, "R8 no sof when idle", 32'(sof_o), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule